// File: doc/BRIEF.md
# MDIO Management Master

This block is the bus-side master of a two-wire PHY management link. A single-cycle request carries a read or write, the framing style (Clause 22 or Clause 45), a 5-bit PHY address, a 5-bit register or device field, a 16-bit extended register address and write data. The master generates MDC from the system clock and shifts the frame out on MDIO. The MDIO pad is split into a data output, an output enable and an input. When the frame finishes, the master returns read data and a turnaround-error flag, qualified by a one-cycle done pulse.

Each frame opens with a run of 32 ones. Clause 22 transfers use a single frame. A Clause 45 transfer sends an address frame first and then a separate read or write frame to the same PHY and device. On a read, the master releases the line and samples the turnaround bit. If no PHY pulls that bit low, the master clocks out 32 slots to flush the bus and returns all ones with an error flag. PHYs known to leave the turnaround undriven can be exempted from this check, one mask bit per address.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever idle, `mdc` is low, `mdio_oe` is low, `req_ready` is high and `rsp_done` is low.
- R2: While busy, MDC has a 50% duty cycle and a period of 2*HALF_DIV system clocks. The default HALF_DIV of 20 gives 400 ns at a 100 MHz clock.
- R3: `mdio_o` and `mdio_oe` never change while `mdc` is high. They change only on the system clock edge at which MDC falls, or when a request is accepted.
- R4: Every frame starts with 32 driven ones, followed MSB first by start bits, opcode, PHY address and register/device field. Clause 22 uses start 01 with opcode 10 for read and 01 for write. A read frame drives exactly these 46 bits.
- R5: A write frame drives 64 bits, ending with turnaround 1,0 and 16 data bits MSB first. After it the master releases MDIO for exactly one MDC cycle, and then `rsp_ta_err` is 0.
- R6: On a read the master samples the released line near the MDC falling edge through a two-flop synchronizer. A 0 turnaround is followed by 16 data bits MSB first and one more released cycle, 18 released cycles in all. The data appears on `rsp_rdata` with `rsp_ta_err` 0.
- R7: If the read turnaround bit is 1 and the PHY's mask bit is clear, the master clocks 32 more released cycles (33 in all). It then returns 16'hFFFF with `rsp_ta_err` 1.
- R8: If bit `req_phy` of `ta_ignore_mask` is 1, the turnaround value is not checked and the read completes as in R6.
- R9: A Clause 45 request first sends an address frame: start 00, opcode 00, the device field, turnaround 1,0 and the 16-bit `req_addr`, followed by one released cycle. It then sends a start-00 frame to the same PHY and device with opcode 11 (read) or 01 (write).
- R10: A request is accepted only when `req_ready` is high. A request raised while busy has no effect on the frames sent or the result returned.
- R11: `rsp_done` is a one-cycle pulse that ends each transfer and returns the master to idle. For writes `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | High while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_c45 | input | 1 | 1 = Clause 45 two-frame access |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address (Clause 22) or device address (Clause 45) |
| req_addr | input | 16 | Clause 45 register address |
| req_wdata | input | 16 | Write data |
| ta_ignore_mask | input | 32 | Per-PHY bypass of the read turnaround check |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result (all ones on turnaround error) |
| rsp_ta_err | output | 1 | Turnaround error flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data to the pad |
| mdio_oe | output | 1 | MDIO pad drive enable |
| mdio_i | input | 1 | MDIO pad input |

## Verification
The assertions assume that `ta_ignore_mask` and the request fields stay steady while a request is pending. They also assume that a PHY presents its read bit within HALF_DIV minus the synchronizer depth clocks of the MDC rise. The bench changes request fields only at the negative clock edge while idle. Its PHY model drives the released line right after each MDC rising edge, and HALF_DIV is set to 4 so that this margin holds. When released and undriven, the line reads as pulled up.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int PRE_BITS   = 32;
   localparam int PHY_AW     = 5;
   localparam int REG_AW     = 5;
   localparam int DATA_W     = 16;
   localparam int FLUSH_BITS = 32;
   localparam int NUM_PHY    = 1 << PHY_AW;
   localparam int HDR_BITS   = 4 + PHY_AW + REG_AW;
   localparam int RD_BITS    = PRE_BITS + HDR_BITS;
   localparam int WR_BITS    = RD_BITS + 2 + DATA_W;

   localparam logic [1:0] SOF_C22   = 2'b01;
   localparam logic [1:0] SOF_C45   = 2'b00;
   localparam logic [1:0] OP22_RD   = 2'b10;
   localparam logic [1:0] OP22_WR   = 2'b01;
   localparam logic [1:0] OP45_ADR  = 2'b00;
   localparam logic [1:0] OP45_RD   = 2'b11;
   localparam logic [1:0] OP45_WR   = 2'b01;
   localparam logic [1:0] TA_DRIVE  = 2'b10;

   typedef logic [WR_BITS-1:0] frame_t;

   typedef enum logic [2:0] {
      MS_IDLE, MS_SHIFT, MS_TURN, MS_CAPT, MS_TAIL, MS_FLUSH
   } mstate_t;

   function automatic frame_t mk_frame(input logic c45, input logic [1:0] op,
                                       input logic [PHY_AW-1:0] phy,
                                       input logic [REG_AW-1:0] ra,
                                       input logic [DATA_W-1:0] pay);
      return {{PRE_BITS{1'b1}}, (c45 ? SOF_C45 : SOF_C22), op, phy, ra, TA_DRIVE, pay};
   endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int HALF_DIV = 20
)(
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tk,
   output logic fall_tk
);
   localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);

   if (HALF_DIV < 2) begin : g_bad_div
      $error("mdio_clkgen: HALF_DIV must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap    = run && (cnt == CW'(HALF_DIV - 1));
   assign rise_tk = wrap && !mdc;
   assign fall_tk = wrap && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end
endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("mdio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int HALF_DIV    = 20,
   parameter int SYNC_STAGES = 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic               req_c45,
   input  logic [PHY_AW-1:0]  req_phy,
   input  logic [REG_AW-1:0]  req_reg,
   input  logic [DATA_W-1:0]  req_addr,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic [NUM_PHY-1:0] ta_ignore_mask,
   output logic               rsp_done,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic               rsp_ta_err,
   output logic               mdc,
   output logic               mdio_o,
   output logic               mdio_oe,
   input  logic               mdio_i
);
   localparam int TXW = $clog2(WR_BITS + 1);
   localparam int RXW = $clog2(FLUSH_BITS + 1);

   if (HALF_DIV <= SYNC_STAGES) begin : g_bad_margin
      $error("mdio_master: HALF_DIV must exceed SYNC_STAGES");
   end

   mstate_t             state;
   frame_t              frame_q;
   logic [TXW-1:0]      tx_left;
   logic [RXW-1:0]      rx_cnt;
   logic                rd_fr_q, pend_q, wr_q, err_q;
   logic [PHY_AW-1:0]   phy_q;
   logic [REG_AW-1:0]   reg_q;
   logic [DATA_W-1:0]   wdata_q, rd_sh;
   logic                rise_tk, fall_tk, smp, finish;

   mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(state != MS_IDLE),
      .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
   );

   mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(mdio_i), .q(smp)
   );

   assign req_ready = (state == MS_IDLE);
   assign mdio_oe   = (state == MS_SHIFT);
   assign mdio_o    = mdio_oe & frame_q[WR_BITS-1];
   assign finish    = fall_tk && ((state == MS_TAIL) ||
                      ((state == MS_FLUSH) && (rx_cnt == RXW'(1))));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= MS_IDLE;
         frame_q    <= '0;
         tx_left    <= '0;
         rx_cnt     <= '0;
         rd_fr_q    <= 1'b0;
         pend_q     <= 1'b0;
         wr_q       <= 1'b0;
         err_q      <= 1'b0;
         phy_q      <= '0;
         reg_q      <= '0;
         wdata_q    <= '0;
         rd_sh      <= '0;
         rsp_done   <= 1'b0;
         rsp_rdata  <= '0;
         rsp_ta_err <= 1'b0;
      end else begin
         rsp_done <= 1'b0;
         unique case (state)
            MS_IDLE: if (req_valid) begin
               wr_q    <= req_write;
               phy_q   <= req_phy;
               reg_q   <= req_reg;
               wdata_q <= req_wdata;
               err_q   <= 1'b0;
               rd_sh   <= '0;
               state   <= MS_SHIFT;
               if (req_c45) begin
                  frame_q <= mk_frame(1'b1, OP45_ADR, req_phy, req_reg, req_addr);
                  rd_fr_q <= 1'b0;
                  tx_left <= TXW'(WR_BITS);
                  pend_q  <= 1'b1;
               end else begin
                  frame_q <= mk_frame(1'b0, req_write ? OP22_WR : OP22_RD,
                                      req_phy, req_reg, req_wdata);
                  rd_fr_q <= !req_write;
                  tx_left <= req_write ? TXW'(WR_BITS) : TXW'(RD_BITS);
                  pend_q  <= 1'b0;
               end
            end
            MS_SHIFT: if (fall_tk) begin
               frame_q <= frame_q << 1;
               tx_left <= tx_left - TXW'(1);
               if (tx_left == TXW'(1)) state <= rd_fr_q ? MS_TURN : MS_TAIL;
            end
            MS_TURN: if (fall_tk) begin
               if (!smp || ta_ignore_mask[phy_q]) begin
                  state  <= MS_CAPT;
                  rx_cnt <= RXW'(DATA_W);
               end else begin
                  state  <= MS_FLUSH;
                  rx_cnt <= RXW'(FLUSH_BITS);
                  err_q  <= 1'b1;
               end
            end
            MS_CAPT: if (fall_tk) begin
               rd_sh  <= {rd_sh[DATA_W-2:0], smp};
               rx_cnt <= rx_cnt - RXW'(1);
               if (rx_cnt == RXW'(1)) state <= MS_TAIL;
            end
            MS_FLUSH: if (fall_tk) rx_cnt <= rx_cnt - RXW'(1);
            default: ;
         endcase

         if (finish) begin
            if (pend_q) begin
               pend_q  <= 1'b0;
               frame_q <= mk_frame(1'b1, wr_q ? OP45_WR : OP45_RD, phy_q, reg_q, wdata_q);
               rd_fr_q <= !wr_q;
               tx_left <= wr_q ? TXW'(WR_BITS) : TXW'(RD_BITS);
               state   <= MS_SHIFT;
            end else begin
               state      <= MS_IDLE;
               rsp_done   <= 1'b1;
               rsp_ta_err <= err_q;
               rsp_rdata  <= err_q ? '1 : (wr_q ? '0 : rd_sh);
            end
         end
      end
   end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_ready,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe,
   input logic        rsp_done,
   input logic [15:0] rsp_rdata,
   input logic        rsp_ta_err
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mdc && !mdio_oe));

   p_mdc_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> !req_ready);

   p_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

   p_err_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_ta_err) |-> (rsp_rdata == 16'hFFFF));

   p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready);
endmodule

bind mdio_master mdio_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rsp_done(rsp_done),
   .rsp_rdata(rsp_rdata), .rsp_ta_err(rsp_ta_err)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
   localparam int CLK_NS = 10;
   localparam int HALF   = 4;
   localparam logic [31:0] MASK = 32'h0000_0040;

   typedef struct packed {
      logic        wr;
      logic        c45;
      logic [4:0]  phy;
      logic [4:0]  ra;
      logic [15:0] addr;
      logic [15:0] data;
      logic        ta_bad;
   } vec_t;

   localparam logic [44:0] VECS [8] = '{
      {1'b0, 1'b0, 5'd1,  5'd2,  16'h0000, 16'h1234, 1'b0},
      {1'b1, 1'b0, 5'd3,  5'd31, 16'h0000, 16'hA5C3, 1'b0},
      {1'b0, 1'b0, 5'd5,  5'd0,  16'h0000, 16'h7777, 1'b1},
      {1'b0, 1'b0, 5'd6,  5'd3,  16'h0000, 16'h0F0F, 1'b1},
      {1'b0, 1'b1, 5'd17, 5'd3,  16'hBEEF, 16'h5555, 1'b0},
      {1'b1, 1'b1, 5'd31, 5'd30, 16'h0001, 16'hFFFF, 1'b0},
      {1'b0, 1'b0, 5'd0,  5'd1,  16'h0000, 16'h0000, 1'b0},
      {1'b0, 1'b1, 5'd9,  5'd1,  16'h8000, 16'hAAAA, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_c45 = 1'b0;
   logic [4:0] req_phy = '0, req_reg = '0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic req_ready, rsp_done, rsp_ta_err, mdc, mdio_o, mdio_oe, mdio_line;
   logic [15:0] rsp_rdata;

   logic        phy_drv = 1'b0, phy_val = 1'b0, phy_ta_bad = 1'b0, rd_act = 1'b0;
   logic [15:0] phy_rdata = '0;
   logic [63:0] cap = '0;
   logic [63:0] frames [4];
   int          lens [4];
   int          nf = 0, run_len = 0, rel = 0;
   int          n_chk = 0, n_err = 0, r3_bad = 0;
   logic        prev_o = 1'b0, prev_oe = 1'b0;
   logic [15:0] got_rdata;
   logic        got_err;

   always #(CLK_NS/2) clk = ~clk;

   assign mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

   mdio_master #(.HALF_DIV(HALF), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_c45(req_c45), .req_phy(req_phy), .req_reg(req_reg),
      .req_addr(req_addr), .req_wdata(req_wdata), .ta_ignore_mask(MASK),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_ta_err(rsp_ta_err),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
   );

   // PHY model: records driven bits, answers reads after each MDC rise
   always @(posedge mdc) begin
      if (mdio_oe) begin
         cap = {cap[62:0], mdio_o};
         run_len++;
         phy_drv = 1'b0;
      end else begin
         if (run_len != 0) begin
            if (nf < 4) begin
               frames[nf] = cap;
               lens[nf]   = run_len;
            end
            nf++;
            rd_act  = (run_len == 46);
            run_len = 0;
            rel     = 0;
         end
         if (rd_act && rel == 0) begin
            phy_drv = !phy_ta_bad;
            phy_val = 1'b0;
         end else if (rd_act && rel >= 1 && rel <= 16) begin
            phy_drv = 1'b1;
            phy_val = phy_rdata[16-rel];
         end else begin
            phy_drv = 1'b0;
         end
         rel++;
      end
   end

   // R3 monitor: outputs must not move while MDC is high
   always @(negedge clk) begin
      if (rst_n && mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) r3_bad++;
      prev_o  = mdio_o;
      prev_oe = mdio_oe;
   end

   task automatic check(input logic ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [45:0] ehdr(input logic [1:0] st, input logic [1:0] op,
                                        input logic [4:0] p, input logic [4:0] r);
      return {32'hFFFF_FFFF, st, op, p, r};
   endfunction

   task automatic wait_done();
      logic got = 1'b0;
      for (int k = 0; k < 20000 && !got; k++) begin
         @(negedge clk);
         if (rsp_done) begin
            got       = 1'b1;
            got_rdata = rsp_rdata;
            got_err   = rsp_ta_err;
         end
      end
      check(got, "R11 done timeout", 64'(got), 64'd1);
   endtask

   task automatic issue(input vec_t v);
      phy_rdata  = v.data;
      phy_ta_bad = v.ta_bad;
      nf         = 0;
      req_write  = v.wr;
      req_c45    = v.c45;
      req_phy    = v.phy;
      req_reg    = v.ra;
      req_addr   = v.addr;
      req_wdata  = v.data;
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid  = 1'b0;
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(!mdc && !mdio_oe && req_ready && !rsp_done, "R1 reset idle",
            {60'd0, mdc, mdio_oe, req_ready, rsp_done}, 64'h2);

      for (int i = 0; i < 8; i++) begin
         vec_t v;
         logic bad;
         int f;
         logic [1:0] st, op;
         v   = VECS[i];
         bad = v.ta_bad && !MASK[v.phy];
         issue(v);
         wait_done();
         check(nf == (v.c45 ? 2 : 1), v.c45 ? "R9 frame count" : "R4 frame count",
               64'(nf), v.c45 ? 64'd2 : 64'd1);
         if (v.c45)
            check(lens[0] == 64 && frames[0] == {ehdr(2'b00, 2'b00, v.phy, v.ra), 2'b10, v.addr},
                  "R9 address frame", frames[0], {ehdr(2'b00, 2'b00, v.phy, v.ra), 2'b10, v.addr});
         f  = v.c45 ? 1 : 0;
         st = v.c45 ? 2'b00 : 2'b01;
         op = v.wr ? 2'b01 : (v.c45 ? 2'b11 : 2'b10);
         if (v.wr) begin
            check(lens[f] == 64 && frames[f] == {ehdr(st, op, v.phy, v.ra), 2'b10, v.data},
                  v.c45 ? "R9 write frame" : "R5 write frame",
                  frames[f], {ehdr(st, op, v.phy, v.ra), 2'b10, v.data});
            check(rel == 1, "R5 one released cycle", 64'(rel), 64'd1);
            check(!got_err && got_rdata == 16'h0, "R11 write result",
                  {47'd0, got_err, got_rdata}, 64'd0);
         end else begin
            check(lens[f] == 46 && frames[f][45:0] == ehdr(st, op, v.phy, v.ra),
                  v.c45 ? "R9 read frame" : "R4 read frame",
                  {18'd0, frames[f][45:0]}, {18'd0, ehdr(st, op, v.phy, v.ra)});
            check(rel == (bad ? 33 : 18), bad ? "R7 flush length" : "R6 released cycles",
                  64'(rel), bad ? 64'd33 : 64'd18);
            check(got_rdata == (bad ? 16'hFFFF : v.data) && got_err == bad,
                  bad ? "R7 error result" : (v.ta_bad ? "R8 mask bypass" : "R6 read data"),
                  {47'd0, got_err, got_rdata}, {47'd0, bad, bad ? 16'hFFFF : v.data});
         end
      end

      // R2: MDC period and high time
      begin
         vec_t v;
         realtime t0, t1, t2;
         v = VECS[1];
         issue(v);
         @(posedge mdc); @(posedge mdc); t0 = $realtime;
         @(negedge mdc); t1 = $realtime;
         @(posedge mdc); t2 = $realtime;
         check(int'(t2 - t0) == 2 * HALF * CLK_NS, "R2 MDC period",
               64'(int'(t2 - t0)), 64'(2 * HALF * CLK_NS));
         check(int'(t1 - t0) == HALF * CLK_NS, "R2 MDC high time",
               64'(int'(t1 - t0)), 64'(HALF * CLK_NS));
         wait_done();
      end

      // R10: request while busy is ignored
      begin
         vec_t v;
         logic was_ready;
         v = {1'b0, 1'b0, 5'd2, 5'd4, 16'h0000, 16'h8001, 1'b0};
         issue(v);
         repeat (100) @(negedge clk);
         was_ready = req_ready;
         req_write = 1'b1; req_c45 = 1'b1; req_phy = 5'd7; req_reg = 5'd9;
         req_wdata = 16'h1111;
         req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         wait_done();
         check(!was_ready, "R10 ready low while busy", 64'(was_ready), 64'd0);
         check(nf == 1 && frames[0][45:0] == ehdr(2'b01, 2'b10, 5'd2, 5'd4),
               "R10 frame unaffected", {18'd0, frames[0][45:0]},
               {18'd0, ehdr(2'b01, 2'b10, 5'd2, 5'd4)});
         check(got_rdata == 16'h8001 && !got_err, "R10 result unaffected",
               {47'd0, got_err, got_rdata}, 64'h8001);
         repeat (200) @(negedge clk);
         check(nf == 1 && req_ready && !mdc && !mdio_oe, "R1 stays idle after done",
               {32'(nf), 29'd0, req_ready, mdc, mdio_oe}, {32'd1, 32'h4});
      end

      check(r3_bad == 0, "R3 outputs stable while MDC high", 64'(r3_bad), 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule